// File: doc/BRIEF.md
# PS/2 Receiver with Parity Resend Request

This block takes the clock and data lines of a PS/2 keyboard or mouse and turns the device's serial frames into bytes. Both lines pass through synchronizers. DATA is then sampled on each falling edge of the synchronized device clock. A frame is checked bit by bit: a low start bit, eight data bits sent least significant first, an odd parity bit and a high stop bit. Each good byte leaves the block with a single-cycle strobe.

The block does not stay silent when the parity check fails. It drops the byte and pulses a request so that the neighbouring transmitter sends the resend command (0xFE) to the device. A bad stop bit, or a device that stalls part-way through a frame, gives a one-cycle error pulse and returns the receiver to waiting for a start bit. While the transmitter is driving the lines toward the device, reception is held off.

Top module: `ps2_rx_resend`

## Requirements
- R1: After reset, rx_valid_o, resend_req_o and frame_error_o are low, and the receiver waits for a start bit.
- R2: While the receiver waits for a start bit, a falling edge that samples DATA high is ignored. No pulse is produced, and the receiver keeps waiting for a start bit.
- R3: A frame is a low start bit, eight data bits with the first one received placed in bit 0, a parity bit and a high stop bit, each taken on a falling CLK edge. After the stop edge, rx_valid_o is high for exactly one cycle, with the byte on rx_data_o. This happens SYNC_STAGES+1 clock cycles after that falling edge reaches the pins.
- R4: Parity is odd: the data bits and the parity bit together must contain an odd number of ones.
- R5: On a parity mismatch the byte is not delivered. resend_req_o pulses for one cycle, at the same latency as R3, and the receiver returns to waiting for a start bit. The transmitter answers that pulse with command 0xFE.
- R6: If the stop bit samples low, the byte is discarded, frame_error_o pulses for one cycle, and the receiver returns to waiting for a start bit. At most one of the three pulse outputs is high in any cycle.
- R7: Every falling CLK edge restarts an inactivity timer. If TIMEOUT_CYC cycles pass after a mid-frame bit takes effect with no further edge, frame_error_o pulses once and the partial frame is dropped. Pauses shorter than that leave the frame intact.
- R8: Inactivity while the receiver waits for a start bit produces no pulse.
- R9: While tx_busy_i is high, falling edges are ignored, any partial frame is dropped, and no pulse is produced. Reception resumes normally once tx_busy_i falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ps2_clk_i | input | 1 | Device clock line as read from the pin (asynchronous) |
| ps2_data_i | input | 1 | Device data line as read from the pin (asynchronous) |
| tx_busy_i | input | 1 | The transmitter is driving a host-to-device transfer |
| rx_data_o | output | 8 | Last byte received with good parity and stop |
| rx_valid_o | output | 1 | One-cycle strobe for a new rx_data_o |
| resend_req_o | output | 1 | One-cycle request to send the resend command |
| frame_error_o | output | 1 | One-cycle pulse for a bad stop bit or a mid-frame timeout |

## Verification
Good frames carrying 0xA5, 0x00, 0xFF, 0x3C and 0x81 test bit ordering and the odd-parity rule at both extremes of the ones count. Stray high start bits, a corrupted parity bit and a low stop bit are then placed ahead of good frames, so that each fault shows as its own pulse without spoiling the frame that follows. A frame abandoned part-way is told apart from one that only pauses for less than the timeout. Long idle stretches and frames sent while the transmitter is busy show that neither one leaks a pulse. A behavioural model predicts the exact cycle of every strobe.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;
  localparam int unsigned DATA_BITS = 8;

  typedef enum logic [1:0] {
    PH_START  = 2'd0,
    PH_DATA   = 2'd1,
    PH_PARITY = 2'd2,
    PH_STOP   = 2'd3
  } phase_e;
endpackage

// File: rtl/ps2_rx_sync.sv
module ps2_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ps2_clk_i,
  input  logic ps2_data_i,
  output logic fall_o,
  output logic data_o
);
  logic [STAGES-1:0] clk_sr, dat_sr;
  logic              clk_prev;

  // lines idle high, so reset to ones to avoid a false edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_sr   <= '1;
      dat_sr   <= '1;
      clk_prev <= 1'b1;
    end else begin
      clk_sr   <= {clk_sr[STAGES-2:0], ps2_clk_i};
      dat_sr   <= {dat_sr[STAGES-2:0], ps2_data_i};
      clk_prev <= clk_sr[STAGES-1];
    end
  end

  assign fall_o = clk_prev & ~clk_sr[STAGES-1];
  assign data_o = dat_sr[STAGES-1];

  assert_fall_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/ps2_rx_timer.sv
module ps2_rx_timer #(
  parameter int unsigned TIMEOUT_CYC = 20000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(TIMEOUT_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt <= '0;
    else if (kick_i)           cnt <= LOAD;
    else if (cnt != '0)        cnt <= cnt - 1'b1;
  end

  assign expire_o = (cnt == CW'(1));

  assert_reload_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> cnt == LOAD);
  assert_expire_drain_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !kick_i) |=> cnt == '0);
endmodule

// File: rtl/ps2_rx_frame.sv
module ps2_rx_frame
  import ps2_rx_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fall_i,
  input  logic                 bit_i,
  input  logic                 expire_i,
  input  logic                 tx_busy_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 valid_o,
  output logic                 resend_o,
  output logic                 error_o
);
  localparam int unsigned CW = $clog2(DATA_BITS);
  localparam logic [CW-1:0] LAST = CW'(DATA_BITS - 1);

  phase_e               phase;
  logic [CW-1:0]        bit_cnt;
  logic [DATA_BITS-1:0] shreg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase    <= PH_START;
      bit_cnt  <= '0;
      shreg    <= '0;
      data_o   <= '0;
      valid_o  <= 1'b0;
      resend_o <= 1'b0;
      error_o  <= 1'b0;
    end else begin
      valid_o  <= 1'b0;
      resend_o <= 1'b0;
      error_o  <= 1'b0;
      if (tx_busy_i) begin
        phase <= PH_START;
      end else if (fall_i) begin
        unique case (phase)
          PH_START: if (!bit_i) begin
            phase   <= PH_DATA;
            bit_cnt <= '0;
          end
          PH_DATA: begin
            shreg   <= {bit_i, shreg[DATA_BITS-1:1]};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST) phase <= PH_PARITY;
          end
          PH_PARITY: begin
            // odd parity: expected bit is the complement of the data XOR
            if (bit_i == ~^shreg) phase <= PH_STOP;
            else begin
              resend_o <= 1'b1;
              phase    <= PH_START;
            end
          end
          PH_STOP: begin
            phase <= PH_START;
            if (bit_i) begin
              valid_o <= 1'b1;
              data_o  <= shreg;
            end else begin
              error_o <= 1'b1;
            end
          end
          default: phase <= PH_START;
        endcase
      end else if (expire_i && phase != PH_START) begin
        phase   <= PH_START;
        error_o <= 1'b1;
      end
    end
  end

  assert_start_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_START && fall_i && bit_i) |=> (phase == PH_START && !valid_o && !error_o));
  assert_busy_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_busy_i |=> (phase == PH_START && !valid_o && !resend_o && !error_o));
  assert_valid_after_stop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(phase) == PH_STOP);
  assert_resend_after_parity_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resend_o |-> ($past(phase) == PH_PARITY && phase == PH_START));
endmodule

// File: rtl/ps2_rx_resend.sv
module ps2_rx_resend
  import ps2_rx_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 200_000_000,
  parameter int unsigned TIMEOUT_US  = 100,
  parameter int unsigned TIMEOUT_CYC = (CLK_HZ / 1_000_000) * TIMEOUT_US,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ps2_clk_i,
  input  logic       ps2_data_i,
  input  logic       tx_busy_i,
  output logic [7:0] rx_data_o,
  output logic       rx_valid_o,
  output logic       resend_req_o,
  output logic       frame_error_o
);
  logic fall, sbit, expire;

  ps2_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ps2_clk_i  (ps2_clk_i),
    .ps2_data_i (ps2_data_i),
    .fall_o     (fall),
    .data_o     (sbit)
  );

  ps2_rx_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .kick_i   (fall),
    .expire_o (expire)
  );

  ps2_rx_frame u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fall_i    (fall),
    .bit_i     (sbit),
    .expire_i  (expire),
    .tx_busy_i (tx_busy_i),
    .data_o    (rx_data_o),
    .valid_o   (rx_valid_o),
    .resend_o  (resend_req_o),
    .error_o   (frame_error_o)
  );

  assert_pulses_exclusive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rx_valid_o, resend_req_o, frame_error_o}));
endmodule

// File: tb/ps2_rx_resend_bench.sv
module ps2_rx_resend_bench;
  localparam int TO   = 64;
  localparam int HALF = 8;
  localparam int LAT  = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ps2_clk = 1'b1;
  logic       ps2_data = 1'b1;
  logic       tx_busy = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, resend_req, frame_error;

  always #2.5 clk = ~clk;

  ps2_rx_resend #(.TIMEOUT_CYC(TO)) u_ps2_rx_resend (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .ps2_clk_i    (ps2_clk),
    .ps2_data_i   (ps2_data),
    .tx_busy_i    (tx_busy),
    .rx_data_o    (rx_data),
    .rx_valid_o   (rx_valid),
    .resend_req_o (resend_req),
    .frame_error_o(frame_error)
  );

  int checks = 0, fails = 0, cyc = 0;
  int n_v = 0, n_rs = 0, n_fe = 0;

  typedef struct { int due; bit b; } pend_t;
  pend_t pq[$];

  int       step = 0, last_due = -1000;
  bit [7:0] mb;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // reference model, stepped and compared once per clock
  always @(negedge clk) begin
    bit    ev, er, ef;
    bit [7:0] ed;
    string tag;
    if (rst_n) begin
      ev = 0; er = 0; ef = 0; ed = 0; tag = "R1";
      if (tx_busy) step = 0;
      if (pq.size() > 0 && pq[0].due == cyc) begin
        pend_t p;
        p = pq.pop_front();
        last_due = cyc;
        if (tx_busy) tag = "R9";
        else if (step == 0) begin
          if (p.b == 1'b0) step = 1; else tag = "R2";
        end else if (step <= 8) begin
          mb[step-1] = p.b;
          step++;
        end else if (step == 9) begin
          if ((($countones(mb) + p.b) % 2) == 1) step = 10;
          else begin er = 1; step = 0; tag = "R5"; end
        end else begin
          step = 0;
          if (p.b) begin ev = 1; ed = mb; tag = "R3,R4"; end
          else begin ef = 1; tag = "R6"; end
        end
      end else if (step != 0 && !tx_busy && cyc == last_due + TO) begin
        ef = 1; step = 0; tag = "R7";
      end
      chk(rx_valid == ev, {tag, " rx_valid"}, rx_valid, ev);
      chk(resend_req == er, {tag, " resend_req"}, resend_req, er);
      chk(frame_error == ef, {tag, " frame_error"}, frame_error, ef);
      if (ev) chk(rx_data == ed, {tag, " rx_data"}, rx_data, ed);
      n_v  += int'(rx_valid);
      n_rs += int'(resend_req);
      n_fe += int'(frame_error);
    end
  end

  task automatic send_bit(input bit b);
    @(negedge clk);
    ps2_data = b;
    repeat (HALF) @(negedge clk);
    ps2_clk = 1'b0;
    pq.push_back('{cyc + LAT, b});
    repeat (HALF) @(negedge clk);
    ps2_clk = 1'b1;
  endtask

  task automatic send_frame(input bit [7:0] d, input bit par_ok, input bit stop);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    send_bit((~^d) ^ !par_ok);
    send_bit(stop);
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end

  initial begin
    int v0, r0, f0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!rx_valid && !resend_req && !frame_error, "R1 reset outputs",
        {rx_valid, resend_req, frame_error}, 0);

    // R3, R4: good frames with varied ones count
    v0 = n_v;
    send_frame(8'hA5, 1, 1);
    send_frame(8'h00, 1, 1);
    send_frame(8'hFF, 1, 1);
    send_frame(8'h3C, 1, 1);
    send_frame(8'h81, 1, 1);
    chk(n_v - v0 == 5, "R3 good frame count", n_v - v0, 5);

    // R2: stray high start bits before a frame
    v0 = n_v; f0 = n_fe;
    send_bit(1'b1);
    send_bit(1'b1);
    send_frame(8'h5A, 1, 1);
    chk(n_v - v0 == 1 && n_fe == f0, "R2 stray start ignored", n_v - v0, 1);

    // R5: parity fault then recovery
    v0 = n_v; r0 = n_rs;
    send_frame(8'h37, 0, 1);
    chk(n_rs - r0 == 1 && n_v == v0, "R5 resend on parity", n_rs - r0, 1);
    send_frame(8'h6E, 1, 1);
    chk(n_v - v0 == 1, "R5 recovery frame", n_v - v0, 1);

    // R6: low stop bit
    v0 = n_v; f0 = n_fe;
    send_frame(8'h42, 1, 0);
    chk(n_fe - f0 == 1 && n_v == v0, "R6 stop error", n_fe - f0, 1);

    // R7: abandoned frame times out
    f0 = n_fe; v0 = n_v;
    send_bit(1'b0);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    repeat (TO + 40) @(negedge clk);
    chk(n_fe - f0 == 1, "R7 timeout error", n_fe - f0, 1);
    send_frame(8'hC3, 1, 1);
    chk(n_v - v0 == 1, "R7 frame after timeout", n_v - v0, 1);

    // R7: pause shorter than the timeout keeps the frame
    f0 = n_fe; v0 = n_v;
    send_bit(1'b0);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    repeat (TO - 2 * HALF - LAT - 6) @(negedge clk);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
    send_bit(~^8'b1001_0110);
    send_bit(1'b1);
    repeat (10) @(negedge clk);
    chk(n_v - v0 == 1 && n_fe == f0, "R7 pause reload", n_v - v0, 1);

    // R8: idle inactivity
    f0 = n_fe;
    repeat (4 * TO) @(negedge clk);
    chk(n_fe == f0, "R8 idle no error", n_fe - f0, 0);

    // R9: busy drops partial frame and ignores traffic
    v0 = n_v; r0 = n_rs; f0 = n_fe;
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    repeat (5) @(negedge clk);
    tx_busy = 1'b1;
    repeat (5) @(negedge clk);
    send_frame(8'h99, 1, 1);
    send_frame(8'h11, 0, 1);
    repeat (TO + 10) @(negedge clk);
    chk(n_v == v0 && n_rs == r0 && n_fe == f0, "R9 busy quiet",
        (n_v - v0) + (n_rs - r0) + (n_fe - f0), 0);
    tx_busy = 1'b0;
    repeat (5) @(negedge clk);
    send_frame(8'hE7, 1, 1);
    chk(n_v - v0 == 1, "R9 resume after busy", n_v - v0, 1);

    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end
endmodule